// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block forms the address of a memory operand. It adds up to three terms into a 32-bit offset: a base register value, an index register value scaled by 1, 2, 4 or 8, and a signed displacement. The displacement is either a full 32-bit word or a byte that is sign-extended. The offset is then relocated by the base of one of six cached segment slots to give a linear address. It is also compared with that slot's limit, and an offset beyond the limit raises a fault flag.

The six slots are numbered 0 to 5. Slot 0 holds code, slot 1 holds the stack, and slots 2 to 5 hold data segments. A separate write port loads one slot's base and limit per cycle. A request is presented with `req_valid`, and the result appears one clock later with `rsp_valid`. After reset every slot covers the whole 4 GB space from address zero, so the linear address equals the offset until software loads narrower segments.

Top module: `seg_addr_gen`

## Requirements
- R1: The offset is the sum, modulo 2^32, of `base_val` when `use_base`=1, the scaled index when `use_index`=1, and the extended displacement when `use_disp`=1. Any term whose enable is 0 contributes zero.
- R2: `scale_code` values 0, 1, 2 and 3 multiply `index_val` by 1, 2, 4 and 8 respectively, with the product taken modulo 2^32.
- R3: When `disp_wide`=0, only `disp_val[7:0]` is used, sign-extended from bit 7, and `disp_val[31:8]` has no effect. When `disp_wide`=1, all 32 bits are used.
- R4: `lin_addr` is the base of the slot chosen by `seg_sel`, plus the offset, modulo 2^32.
- R5: `limit_fault` is 1 exactly when the offset is greater than the chosen slot's limit. An offset equal to the limit is allowed.
- R6: `rsp_valid` is `req_valid` delayed by one clock. While no request is accepted, `lin_addr` and `limit_fault` hold their last values.
- R7: After reset, `rsp_valid`, `lin_addr` and `limit_fault` are 0. Every slot has base 0 and limit 0xFFFFFFFF, so the address space is flat.
- R8: When `wr_en`=1, the base and limit of slot `wr_slot` are loaded at the clock edge. A request in that same cycle still sees the old slot contents, and requests in later cycles see the new contents.
- R9: A `seg_sel` of 6 or 7 names no slot. Such a request gives `limit_fault`=1 and `lin_addr` equal to the offset. A write to slot 6 or 7 changes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| use_base | input | 1 | Include base register term |
| base_val | input | 32 | Base register value |
| use_index | input | 1 | Include scaled index term |
| index_val | input | 32 | Index register value |
| scale_code | input | 2 | Index scale, 1 shifted left by this code |
| use_disp | input | 1 | Include displacement term |
| disp_wide | input | 1 | 1: 32-bit displacement, 0: sign-extended byte |
| disp_val | input | 32 | Displacement |
| seg_sel | input | 3 | Segment slot used for the request |
| wr_en | input | 1 | Load a segment slot |
| wr_slot | input | 3 | Slot to load |
| wr_base | input | 32 | New slot base |
| wr_limit | input | 32 | New slot limit |
| rsp_valid | output | 1 | Result valid |
| lin_addr | output | 32 | Linear address |
| limit_fault | output | 1 | Offset exceeds limit, or slot invalid |

## Verification
The hardest case to reach is a request that reads a slot in the same cycle that the write port reloads it. A wrong ordering there shows only as an address or fault from the wrong generation of descriptor. The bench drives exactly that collision with a new base and a tight limit, and then repeats the request in the next cycle. Limit boundaries are hit by setting the limit equal to the offset and then to one less than it. Random requests mixed with random slot writes then cover the remaining term and scale combinations against the reference model.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int AW   = 32,
  parameter int NSEG = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          use_base,
  input  logic [AW-1:0] base_val,
  input  logic          use_index,
  input  logic [AW-1:0] index_val,
  input  logic [1:0]    scale_code,
  input  logic          use_disp,
  input  logic          disp_wide,
  input  logic [AW-1:0] disp_val,
  input  logic [2:0]    seg_sel,
  input  logic          wr_en,
  input  logic [2:0]    wr_slot,
  input  logic [AW-1:0] wr_base,
  input  logic [AW-1:0] wr_limit,
  output logic          rsp_valid,
  output logic [AW-1:0] lin_addr,
  output logic          limit_fault
);
  logic [AW-1:0] seg_base [NSEG];
  logic [AW-1:0] seg_lim  [NSEG];

  genvar g;
  generate
    for (g = 0; g < NSEG; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          seg_base[g] <= '0;
          seg_lim[g]  <= '1;
        end else if (wr_en && wr_slot == 3'(g)) begin
          seg_base[g] <= wr_base;
          seg_lim[g]  <= wr_limit;
        end
      end
    end
  endgenerate

  logic [AW-1:0] disp_ext, scaled, offset, cur_base, cur_lim;
  logic          sel_ok;

  assign disp_ext = disp_wide ? disp_val : {{(AW-8){disp_val[7]}}, disp_val[7:0]};
  assign scaled   = index_val << scale_code;
  assign offset   = (use_base ? base_val : '0)
                  + (use_index ? scaled : '0)
                  + (use_disp ? disp_ext : '0);

  always_comb begin
    sel_ok   = 1'b0;
    cur_base = '0;
    cur_lim  = '0;
    for (int i = 0; i < NSEG; i++) begin
      if (seg_sel == 3'(i)) begin
        sel_ok   = 1'b1;
        cur_base = seg_base[i];
        cur_lim  = seg_lim[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      lin_addr    <= '0;
      limit_fault <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        lin_addr    <= cur_base + offset;
        limit_fault <= !sel_ok || (offset > cur_lim);
      end
    end
  end

  a_r6_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(lin_addr) && $stable(limit_fault)));
  a_r9_bad_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && seg_sel >= 3'(NSEG)) |=> limit_fault);
  a_r5_flat_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sel_ok && cur_lim == '1) |=> !limit_fault);
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_slot == 3'd0) |=> (seg_base[0] == $past(wr_base)));
endmodule

// File: tb/test_seg_addr_gen.sv
module test_seg_addr_gen;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic req_valid = 0, use_base = 0, use_index = 0, use_disp = 0, disp_wide = 0, wr_en = 0;
  logic [31:0] base_val = 0, index_val = 0, disp_val = 0, wr_base = 0, wr_limit = 0;
  logic [1:0]  scale_code = 0;
  logic [2:0]  seg_sel = 0, wr_slot = 0;
  logic        rsp_valid, limit_fault;
  logic [31:0] lin_addr;

  seg_addr_gen i_seg_addr_gen (.*);

  int errors = 0, checks = 0;
  longint m_base [8];
  longint m_lim  [8];
  longint e_addr = 0;
  bit     e_fault = 0;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(string tag);
    longint off, d, idx, b, l;
    bit ev;
    d   = disp_wide ? longint'(disp_val) : longint'($signed(disp_val[7:0]));
    idx = longint'(index_val) * (longint'(1) << scale_code);
    off = 0;
    if (use_base)  off += base_val;
    if (use_index) off += idx;
    if (use_disp)  off += d;
    off = off & 64'hFFFF_FFFF;
    ev = req_valid;
    if (req_valid) begin
      if (seg_sel < 6) begin
        b = m_base[seg_sel]; l = m_lim[seg_sel];
        e_addr  = (b + off) & 64'hFFFF_FFFF;
        e_fault = off > l;
      end else begin
        e_addr = off; e_fault = 1;
      end
    end
    if (wr_en && wr_slot < 6) begin
      m_base[wr_slot] = wr_base;
      m_lim[wr_slot]  = wr_limit;
    end
    @(negedge clk);
    chk({tag, " valid"}, rsp_valid, ev);
    chk({tag, " addr"}, lin_addr, e_addr);
    chk({tag, " fault"}, limit_fault, e_fault);
    req_valid = 0; wr_en = 0;
  endtask

  task automatic req(bit ub, bit ui, bit ud, bit dw, logic [31:0] bv, logic [31:0] iv,
                     logic [1:0] sc, logic [31:0] dv, logic [2:0] sel);
    req_valid = 1; use_base = ub; use_index = ui; use_disp = ud; disp_wide = dw;
    base_val = bv; index_val = iv; scale_code = sc; disp_val = dv; seg_sel = sel;
  endtask

  task automatic wr(logic [2:0] s, logic [31:0] b, logic [31:0] l);
    wr_en = 1; wr_slot = s; wr_base = b; wr_limit = l;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin m_base[i] = 0; m_lim[i] = 64'hFFFF_FFFF; end
    #23 rst_n = 1;
    @(negedge clk);
    chk("R7 reset valid", rsp_valid, 0);
    chk("R7 reset addr", lin_addr, 0);
    chk("R7 reset fault", limit_fault, 0);
    req(1,0,0,0,32'h0000_1000,0,0,0,3'd1); tick("R7 flat slot");
    req(0,0,1,1,0,0,0,32'h1234_5678,3'd0); tick("R1 disp only");
    req(1,1,1,1,32'h100,32'h10,2'd0,32'h4,3'd2); tick("R1 all terms");
    req(1,1,0,0,32'hFFFF_FFF0,32'h20,2'd0,0,3'd3); tick("R1 wrap");
    for (int s = 0; s < 4; s++) begin
      req(0,1,0,0,0,32'h3000_0003,2'(s),0,3'd4); tick("R2 scale");
    end
    req(1,0,1,0,32'h1000,0,0,32'hABCD_EF80,3'd0); tick("R3 byte negative");
    req(1,0,1,0,32'h1000,0,0,32'hFFFF_FF7F,3'd0); tick("R3 byte positive");
    req(0,0,0,0,0,0,0,0,3'd0); tick("R1 no terms");
    wr(3'd2, 32'h4000_0000, 32'h0000_00FF); tick("R8 write only");
    req(1,0,0,0,32'hFF,0,0,0,3'd2); tick("R4 relocate at limit R5");
    req(1,0,0,0,32'h100,0,0,0,3'd2); tick("R5 limit plus one");
    req(1,0,0,0,32'h200,0,0,0,3'd5); wr(3'd5, 32'h8000_0000, 32'h0000_0100); tick("R8 same cycle old");
    req(1,0,0,0,32'h200,0,0,0,3'd5); tick("R8 next cycle new");
    tick("R6 idle hold");
    tick("R6 idle hold 2");
    req(1,0,0,0,32'h77,0,0,0,3'd6); tick("R9 slot 6");
    req(1,0,0,0,32'h78,0,0,0,3'd7); tick("R9 slot 7");
    wr(3'd6, 32'h1111_1111, 32'h0); tick("R9 write slot 6");
    for (int s = 0; s < 6; s++) begin
      req(1,0,0,0,32'h10,0,0,0,3'(s)); tick("R9 slots unchanged");
    end
    for (int n = 0; n < 400; n++) begin
      req_valid = $urandom_range(0,3) != 0;
      use_base = $urandom; use_index = $urandom; use_disp = $urandom; disp_wide = $urandom;
      base_val = $urandom; index_val = $urandom; scale_code = 2'($urandom);
      disp_val = $urandom; seg_sel = 3'($urandom);
      wr_en = $urandom_range(0,4) == 0; wr_slot = 3'($urandom);
      wr_base = $urandom; wr_limit = $urandom;
      tick("R1 R4 R5 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule